// File: doc/BRIEF.md
# UART Receive Queue with Trigger Interrupt

This block holds received characters between a serial deserialiser and the software or DMA agent that drains them. Each stored entry is 12 bits wide: eight data bits plus framing-error, parity-error and break flags. Storage is a circular buffer with a read index and an occupancy count. The slot that the next write lands in is the read index plus the count, wrapped at the depth.

A mode input selects between queue mode, where the whole depth is usable, and holding-register mode, where only one entry is accepted at a time. Changing the mode empties the queue, and so does a flush strobe. A line-break event stores a tagged entry with zero data. A receive interrupt is raised when the occupancy climbs to the trigger level. It is withdrawn when a read drops the occupancy back below that level.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, ready is 1, rx_irq is 0 and overrun is 0.
- R2: Entries leave in the order they were stored, including across the wrap of the circular index. head_entry always shows the oldest stored entry.
- R3: In queue mode, full is 1 when count equals DEPTH (16). A push while full is dropped: count and head are unchanged, and overrun is 1 for exactly the one cycle after that push.
- R4: With fifo_en at 0 the usable depth is 1. full rises after a single entry is stored, and a second push is dropped with an overrun pulse.
- R5: A break_evt stores the entry 0x400 (bit 10 set, all other bits zero). A data push in the same cycle is dropped and raises overrun.
- R6: A stored data entry has push_data in bits 7:0, push_err[0] (framing error) in bit 8 and push_err[1] (parity error) in bit 9. Bits 10 and 11 are zero.
- R7: A push that takes count up to the trigger level (TRIG_LEVEL, default 1; 1 in holding-register mode) makes rx_irq_set 1 for one cycle and sets rx_irq, both visible in the cycle after the push.
- R8: rx_irq falls when a pop leaves count at trigger level minus one.
- R9: A pop while empty changes nothing: count stays 0 and head_entry keeps its value.
- R10: A push and a pop in the same cycle on a non-empty, non-full queue leave count unchanged and keep the order.
- R11: The flush strobe, or any change of fifo_en, empties the queue and clears rx_irq in the next cycle.
- R12: ready is 1 exactly when count is below the usable depth and no flush or mode change is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Store a received character this cycle |
| push_data | input | 8 | Received character |
| push_err | input | 2 | [0] framing error, [1] parity error |
| break_evt | input | 1 | Line break detected; stores 0x400 |
| pop | input | 1 | Remove the head entry |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| flush | input | 1 | Empty the queue |
| head_entry | output | 12 | Oldest stored entry |
| count | output | 5 | Number of stored entries |
| empty | output | 1 | count is zero |
| full | output | 1 | count equals usable depth |
| ready | output | 1 | A push this cycle would be stored |
| rx_irq | output | 1 | Receive interrupt level |
| rx_irq_set | output | 1 | One-cycle pulse when the interrupt is raised |
| overrun | output | 1 | One-cycle pulse after a dropped push |

## Verification
The assertions assume that inputs are stable around the rising edge. They also assume that TRIG_LEVEL lies between 1 and DEPTH, so that a trigger is always reachable. Because fifo_en can be switched while entries are held, the occupancy bounds are checked against the registered mode and not against the raw input. The directed stimulus changes every input only one time unit after an edge, and it uses only the default trigger level.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
   localparam int ENTRY_W = 12;
   localparam int DATA_W  = 8;
   localparam int FE_BIT  = 8;
   localparam int PE_BIT  = 9;
   localparam int BRK_BIT = 10;

   typedef logic [ENTRY_W-1:0] rxq_entry_t;

   function automatic rxq_entry_t pack_data(input logic [DATA_W-1:0] d,
                                            input logic [1:0] err);
      rxq_entry_t e;
      e = '0;
      e[DATA_W-1:0] = d;
      e[FE_BIT]     = err[0];
      e[PE_BIT]     = err[1];
      return e;
   endfunction

   function automatic rxq_entry_t break_entry();
      rxq_entry_t e;
      e = '0;
      e[BRK_BIT] = 1'b1;
      return e;
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter bit SLOT_RESET  = 1'b1,
   localparam int PTR_W      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_idx,
   input  rxq_entry_t       wr_entry,
   input  logic [PTR_W-1:0] rd_idx,
   output rxq_entry_t       rd_entry
);
   rxq_entry_t slots [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_idx == PTR_W'(s));
      if (SLOT_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)   slots[s] <= '0;
            else if (hit) slots[s] <= wr_entry;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) slots[s] <= wr_entry;
         end
      end
   end

   assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic             clear,
   input  logic             fifo_mode,
   output logic             wr_ok,
   output logic             rd_ok,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] depth_eff,
   output logic             ready
);
   logic [PTR_W-1:0] rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   slot_sum;

   initial begin
      assert (DEPTH >= 2) else $error("rxq_ptr_ctrl: DEPTH must be at least 2");
   end

   assign depth_eff = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
   assign ready     = !clear && (cnt_q < depth_eff);
   assign wr_ok     = wr_req && ready;
   assign rd_ok     = rd_req && !clear && (cnt_q != '0);

   assign slot_sum = (CNT_W+1)'(rd_q) + (CNT_W+1)'(cnt_q);
   always_comb begin
      if (slot_sum >= (CNT_W+1)'(DEPTH)) wr_idx = PTR_W'(slot_sum - (CNT_W+1)'(DEPTH));
      else                               wr_idx = PTR_W'(slot_sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (rd_ok) rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rd_idx = rd_q;
   assign cnt    = cnt_q;

   // R4: in holding-register mode no more than one entry is ever held
   assert_single_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_mode && $stable(fifo_mode)) |-> cnt_q <= CNT_W'(1));
   // R3: occupancy never passes the full depth
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   // R9: a pop on an empty queue leaves the read index in place
   assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !wr_req && !clear && cnt_q == '0) |=> ($stable(rd_q) && cnt_q == '0));
   // R10: simultaneous accepted push and pop keep the occupancy
   assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && rd_ok) |=> $stable(cnt_q));
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
   parameter int DEPTH      = 16,
   parameter int TRIG_LEVEL = 1,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic             rd_ok,
   input  logic             clear,
   input  logic             fifo_mode,
   input  logic [CNT_W-1:0] cnt,
   output logic             irq_set,
   output logic             irq_level
);
   logic [CNT_W-1:0] trig_eff;
   logic [CNT_W-1:0] cnt_next;
   logic             hit_up, hit_down;
   logic             set_q, lvl_q;

   initial begin
      assert (TRIG_LEVEL >= 1 && TRIG_LEVEL <= DEPTH)
         else $error("rxq_trigger: TRIG_LEVEL out of range");
   end

   assign trig_eff = fifo_mode ? CNT_W'(TRIG_LEVEL) : CNT_W'(1);
   assign cnt_next = cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
   assign hit_up   = wr_ok && !rd_ok && (cnt_next == trig_eff);
   assign hit_down = rd_ok && !wr_ok && (cnt_next == trig_eff - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_q <= 1'b0;
         lvl_q <= 1'b0;
      end else begin
         set_q <= hit_up && !clear;
         if (clear || hit_down) lvl_q <= 1'b0;
         else if (hit_up)       lvl_q <= 1'b1;
      end
   end

   assign irq_set   = set_q;
   assign irq_level = lvl_q;

   // R7: the set pulse coincides with the occupancy at the trigger level
   assert_set_at_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |-> (cnt == trig_eff && irq_level));
   // R8: the interrupt only falls once the occupancy is below the trigger
   assert_drop_below_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_level) |-> cnt < trig_eff);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int TRIG_LEVEL   = 1,
   parameter bit SLOT_RESET   = 1'b1,
   parameter bit RESET_QMODE  = 1'b1,
   localparam int PTR_W       = $clog2(DEPTH),
   localparam int CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_valid,
   input  logic [DATA_W-1:0]  push_data,
   input  logic [1:0]         push_err,
   input  logic               break_evt,
   input  logic               pop,
   input  logic               fifo_en,
   input  logic               flush,
   output logic [ENTRY_W-1:0] head_entry,
   output logic [CNT_W-1:0]   count,
   output logic               empty,
   output logic               full,
   output logic               ready,
   output logic               rx_irq,
   output logic               rx_irq_set,
   output logic               overrun
);
   logic             mode_q;
   logic             mode_chg, clear;
   logic             wr_req, wr_ok, rd_ok;
   logic [PTR_W-1:0] wr_idx, rd_idx;
   logic [CNT_W-1:0] cnt, depth_eff;
   rxq_entry_t       wr_entry, rd_entry;
   logic             ovr_q;

   assign mode_chg = (fifo_en != mode_q);
   assign clear    = flush || mode_chg;
   assign wr_req   = push_valid || break_evt;
   assign wr_entry = break_evt ? break_entry() : pack_data(push_data, push_err);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RESET_QMODE;
         ovr_q  <= 1'b0;
      end else begin
         mode_q <= fifo_en;
         ovr_q  <= (wr_req && !ready) || (push_valid && break_evt);
      end
   end

   rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .rd_req    (pop),
      .clear     (clear),
      .fifo_mode (mode_q),
      .wr_ok     (wr_ok),
      .rd_ok     (rd_ok),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .cnt       (cnt),
      .depth_eff (depth_eff),
      .ready     (ready)
   );

   rxq_store #(.DEPTH(DEPTH), .SLOT_RESET(SLOT_RESET)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok),
      .wr_idx   (wr_idx),
      .wr_entry (wr_entry),
      .rd_idx   (rd_idx),
      .rd_entry (rd_entry)
   );

   rxq_trigger #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ok     (wr_ok),
      .rd_ok     (rd_ok),
      .clear     (clear),
      .fifo_mode (mode_q),
      .cnt       (cnt),
      .irq_set   (rx_irq_set),
      .irq_level (rx_irq)
   );

   assign head_entry = rd_entry;
   assign count      = cnt;
   assign empty      = (cnt == '0);
   assign full       = (cnt == depth_eff);
   assign overrun    = ovr_q;

   // R3: a full queue never reports room
   assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !ready);
   // R3: an overrun pulse always follows a push or break that was not stored
   assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(push_valid || break_evt));
   // R11: a clear leaves the queue empty with no interrupt
   assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (empty && !rx_irq));
endmodule

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [7:0]  push_data = '0;
   logic [1:0]  push_err = '0;
   logic        break_evt = 1'b0;
   logic        pop = 1'b0;
   logic        fifo_en = 1'b1;
   logic        flush = 1'b0;
   logic [11:0] head_entry;
   logic [4:0]  count;
   logic        empty, full, ready, rx_irq, rx_irq_set, overrun;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_fifo u_uart_rx_fifo (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .push_err(push_err), .break_evt(break_evt), .pop(pop), .fifo_en(fifo_en),
      .flush(flush), .head_entry(head_entry), .count(count), .empty(empty),
      .full(full), .ready(ready), .rx_irq(rx_irq), .rx_irq_set(rx_irq_set),
      .overrun(overrun)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push_one(input logic [7:0] d, input logic [1:0] e);
      push_valid = 1'b1; push_data = d; push_err = e;
      step();
      push_valid = 1'b0;
   endtask

   task automatic pop_one();
      pop = 1'b1;
      step();
      pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 count", count, 0);
      chk("R1 empty", empty, 1);
      chk("R1 full", full, 0);
      chk("R1 ready", ready, 1);
      chk("R1 rx_irq", rx_irq, 0);
      chk("R1 overrun", overrun, 0);
   endtask

   task automatic t_order();
      push_one(8'h5A, 2'b00);
      chk("R7 set pulse", rx_irq_set, 1);
      chk("R7 irq level", rx_irq, 1);
      push_one(8'h01, 2'b01);
      chk("R7 pulse one cycle", rx_irq_set, 0);
      push_one(8'hC3, 2'b10);
      push_one(8'hFF, 2'b11);
      chk("R2 count", count, 4);
      chk("R6 plain", head_entry, 12'h05A); pop_one();
      chk("R6 framing", head_entry, 12'h101); pop_one();
      chk("R6 parity", head_entry, 12'h2C3); pop_one();
      chk("R6 both", head_entry, 12'h3FF); pop_one();
      chk("R2 drained", empty, 1);
      chk("R8 irq drop", rx_irq, 0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 16; i++) push_one(8'(8'h20 + i), 2'b00);
      chk("R3 full", full, 1);
      chk("R12 ready low", ready, 0);
      chk("R3 count", count, 16);
      push_one(8'hEE, 2'b00);
      chk("R3 overrun", overrun, 1);
      chk("R3 count kept", count, 16);
      chk("R3 head kept", head_entry, 12'h020);
      step();
      chk("R3 overrun one cycle", overrun, 0);
      for (int i = 0; i < 16; i++) begin
         chk("R2 wrap order", head_entry, 12'h020 + i);
         pop_one();
      end
      chk("R12 ready back", ready, 1);
      chk("R2 empty", empty, 1);
   endtask

   task automatic t_irq();
      push_one(8'hA1, 2'b00);
      chk("R7 set", rx_irq_set, 1);
      push_one(8'hA2, 2'b00);
      chk("R7 no repeat", rx_irq_set, 0);
      pop_one();
      chk("R8 held at 1", rx_irq, 1);
      pop_one();
      chk("R8 cleared", rx_irq, 0);
   endtask

   task automatic t_simul();
      push_one(8'h11, 2'b00);
      push_one(8'h22, 2'b00);
      pop = 1'b1;
      push_one(8'h33, 2'b00);
      pop = 1'b0;
      chk("R10 count", count, 2);
      chk("R10 head", head_entry, 12'h022);
      pop_one();
      chk("R10 order", head_entry, 12'h033);
      pop_one();
      chk("R10 empty", count, 0);
   endtask

   task automatic t_empty_pop();
      logic [11:0] h;
      h = head_entry;
      pop_one();
      chk("R9 count", count, 0);
      chk("R9 head", head_entry, h);
      chk("R9 empty", empty, 1);
   endtask

   task automatic t_break();
      break_evt = 1'b1;
      push_one(8'h77, 2'b11);
      break_evt = 1'b0;
      chk("R5 entry", head_entry, 12'h400);
      chk("R5 count", count, 1);
      chk("R5 overrun", overrun, 1);
      pop_one();
   endtask

   task automatic t_nofifo();
      fifo_en = 1'b0;
      step();
      chk("R11 mode change", count, 0);
      push_one(8'h41, 2'b00);
      chk("R4 full", full, 1);
      chk("R12 ready", ready, 0);
      push_one(8'h42, 2'b00);
      chk("R4 overrun", overrun, 1);
      chk("R4 count", count, 1);
      chk("R4 head", head_entry, 12'h041);
      pop_one();
      fifo_en = 1'b1;
      step();
      chk("R12 ready in queue mode", ready, 1);
      chk("R11 empty", empty, 1);
   endtask

   task automatic t_flush();
      push_one(8'h61, 2'b00);
      push_one(8'h62, 2'b00);
      push_one(8'h63, 2'b00);
      chk("R11 irq before", rx_irq, 1);
      flush = 1'b1;
      step();
      flush = 1'b0;
      chk("R11 count", count, 0);
      chk("R11 empty", empty, 1);
      chk("R11 irq", rx_irq, 0);
      push_one(8'h64, 2'b00);
      chk("R11 fresh head", head_entry, 12'h064);
      chk("R11 count one", count, 1);
      pop_one();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_order();
      t_fill();
      t_irq();
      t_simul();
      t_empty_pop();
      t_break();
      t_nofifo();
      t_flush();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule